// File: doc/BRIEF.md
# Symmetric Transposed FIR Filter

This block is a single-rate finite impulse response filter with 31 taps. Each accepted signed 16-bit input sample yields exactly one filtered output at full precision. The tap weights are symmetric, so the weight of tap k equals the weight of tap 30-k. Only 16 distinct products are formed per sample. Each product is added into two positions of a transposed partial-sum chain. All 16 multipliers work in parallel on every accepted sample, and none of them is shared over time.

The weights can be changed while the filter runs. Software-side logic writes the 16 distinct weights one at a time into a staging bank through an indexed write port. A single commit strobe then moves the whole staging bank into the working bank in one cycle. This lets one instance be switched between low-pass, high-pass, band-pass and band-reject responses. A synchronous clear empties the partial-sum chain and leaves both weight banks untouched. Input gaps are allowed: the chain moves only on cycles that carry a sample.

Top module: `fir_sym_transposed`

## Requirements
- R1: While reset is low and after it is released, outValid is 0 and outSample is 0. Both weight banks reset to zero, so every output stays zero until a commit loads nonzero weights.
- R2: For the accepted input stream x, the filter computes outSample = sum over k=0..30 of w[k]*x[n-k], where x[n] is the newest accepted sample. Samples before reset or before the last clear count as zero. inSample and coefficients are two's-complement signed 16-bit values.
- R3: Distinct-weight index u (0..15) sets both tap u and tap 30-u. Index 15 is the centre tap and is used once.
- R4: outSample is a 37-bit two's-complement value holding the exact sum. The extreme case of 31 products of -32768 by -32768 gives 33285996544 with no wrap or saturation.
- R5: outValid is 1 in the cycle after an accepted sample (inValid=1 and clear=0 at a clock edge) and 0 in every other cycle.
- R6: On cycles with no accepted sample, the chain does not move and outSample keeps its last value. Idle gaps of any length leave later outputs unchanged.
- R7: A weight write with coefWrIdx from 16 to 31 changes neither bank.
- R8: Weight writes land in the staging bank and do not affect outputs until coefCommit. A commit copies all 16 staging entries into the working bank at one clock edge. A sample accepted in the commit cycle still uses the previous working bank. A write in the same cycle as a commit stays in the staging bank only.
- R9: All 16 products of any one sample use a single working bank. After a commit, output n equals the sum of w_j[k]*x[n-k], where w_j is the bank that was active when sample n-k was accepted.
- R10: clear=1 zeroes the partial-sum chain and discards a sample offered in the same cycle, which produces no output. Neither weight bank is altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous chain clear; has priority over inValid |
| inValid | input | 1 | inSample carries a sample this cycle |
| inSample | input | 16 | Signed input sample |
| coefWrEn | input | 1 | Write coefWrData into staging entry coefWrIdx |
| coefWrIdx | input | 5 | Distinct-weight index; 0..15 used, 16..31 ignored |
| coefWrData | input | 16 | Signed weight value |
| coefCommit | input | 1 | Copy the whole staging bank into the working bank |
| outValid | output | 1 | outSample holds a new result |
| outSample | output | 37 | Signed full-precision filter result |

## Verification
The checker assumes that reset is held low for at least one clock edge before any property matters. It also assumes that inValid and clear are driven to known values on every edge after reset, because acceptance is judged from their levels at each edge. The bench drives all inputs on falling edges from known initial values, holds reset for several cycles, and treats clear as a plain level that may coincide with inValid. Every weight switch is predicted by a bench model that records, for each accepted sample, the bank in force when it arrived. This lets outputs across a commit be predicted exactly.

// File: rtl/fir_sym_pkg.sv
package fir_sym_pkg;

  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic advance;  // accept the current sample and move the chain
    logic flush;    // zero the chain
  } firStrobes_t;

  // Guard bits needed to add a given number of full-width products.
  function automatic int guardBits(input int terms);
    return $clog2(terms);
  endfunction

endpackage

// File: rtl/fir_coef_ctrl.sv
module fir_coef_ctrl
  import fir_sym_pkg::*;
#(
  parameter int UNIQUE = 16,
  parameter int COEF_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     inValid,
  input  logic                     coefWrEn,
  input  logic [IDX_W-1:0]         coefWrIdx,
  input  logic signed [COEF_W-1:0] coefWrData,
  input  logic                     coefCommit,
  output firStrobes_t              strobes,
  output logic signed [COEF_W-1:0] activeBank [UNIQUE]
);

  logic signed [COEF_W-1:0] shadowBank [UNIQUE];

  // Clear wins over a sample offered in the same cycle.
  always_comb begin
    strobes.flush   = clear;
    strobes.advance = inValid & ~clear;
  end

  for (genvar u = 0; u < UNIQUE; u++) begin : gEntry
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(u);

    // Staging entry: indices with no matching entry never hit any decode.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadowBank[u] <= '0;
      end else if (coefWrEn && (coefWrIdx == MY_IDX)) begin
        shadowBank[u] <= coefWrData;
      end
    end

    // Working entry: the whole bank swaps at one edge and takes the staging
    // value from before any write in the same cycle.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        activeBank[u] <= '0;
      end else if (coefCommit) begin
        activeBank[u] <= shadowBank[u];
      end
    end
  end

endmodule

// File: rtl/fir_sym_datapath.sv
module fir_sym_datapath
  import fir_sym_pkg::*;
#(
  parameter int TAPS   = 31,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int UNIQUE = (TAPS + 1) / 2,
  parameter int ACC_W  = DATA_W + COEF_W + 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  firStrobes_t              strobes,
  input  logic signed [DATA_W-1:0] inSample,
  input  logic signed [COEF_W-1:0] activeBank [UNIQUE],
  output logic                     outValid,
  output logic signed [ACC_W-1:0]  outSample
);

  localparam int PROD_W = DATA_W + COEF_W;
  localparam int CHAIN  = TAPS - 1;

  logic signed [PROD_W-1:0] uniqueProd [UNIQUE];
  logic signed [ACC_W-1:0]  tapProd    [TAPS];
  logic signed [ACC_W-1:0]  chain      [CHAIN];
  logic signed [ACC_W-1:0]  chainNext  [CHAIN];

  // One multiplier per distinct weight, all in parallel.
  for (genvar u = 0; u < UNIQUE; u++) begin : gMul
    assign uniqueProd[u] = inSample * activeBank[u];
  end

  // Each product serves the tap and its mirror image.
  for (genvar k = 0; k < TAPS; k++) begin : gTap
    localparam int SRC = (k < UNIQUE) ? k : (TAPS - 1 - k);
    assign tapProd[k] = ACC_W'(uniqueProd[SRC]);
  end

  // chain[j] holds the partial sum that feeds tap j+1 on the next sample.
  for (genvar j = 0; j < CHAIN; j++) begin : gChain
    if (j == CHAIN - 1) begin : gLast
      assign chainNext[j] = tapProd[j + 1];
    end else begin : gMid
      assign chainNext[j] = tapProd[j + 1] + chain[j + 1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n || strobes.flush) begin
        chain[j] <= '0;
      end else if (strobes.advance) begin
        chain[j] <= chainNext[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      outSample <= '0;
    end else begin
      outValid <= strobes.advance;
      if (strobes.advance) begin
        outSample <= tapProd[0] + chain[0];
      end
    end
  end

endmodule

// File: rtl/fir_sym_transposed.sv
module fir_sym_transposed
  import fir_sym_pkg::*;
#(
  parameter int TAPS   = 31,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  localparam int UNIQUE = (TAPS + 1) / 2,
  localparam int IDX_W  = $clog2(TAPS),
  localparam int ACC_W  = DATA_W + COEF_W + guardBits(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inSample,
  input  logic                     coefWrEn,
  input  logic [IDX_W-1:0]         coefWrIdx,
  input  logic signed [COEF_W-1:0] coefWrData,
  input  logic                     coefCommit,
  output logic                     outValid,
  output logic signed [ACC_W-1:0]  outSample
);

  firStrobes_t              strobes;
  logic signed [COEF_W-1:0] activeBank [UNIQUE];

  fir_coef_ctrl #(
    .UNIQUE (UNIQUE),
    .COEF_W (COEF_W),
    .IDX_W  (IDX_W)
  ) uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .inValid    (inValid),
    .coefWrEn   (coefWrEn),
    .coefWrIdx  (coefWrIdx),
    .coefWrData (coefWrData),
    .coefCommit (coefCommit),
    .strobes    (strobes),
    .activeBank (activeBank)
  );

  fir_sym_datapath #(
    .TAPS   (TAPS),
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .UNIQUE (UNIQUE),
    .ACC_W  (ACC_W)
  ) uPath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .inSample   (inSample),
    .activeBank (activeBank),
    .outValid   (outValid),
    .outSample  (outSample)
  );

endmodule

// File: rtl/fir_sym_checker.sv
module fir_sym_checker #(
  parameter int ACC_W = 37
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             inValid,
  input logic             outValid,
  input logic [ACC_W-1:0] outSample
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !outValid);

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !clear) |=> outValid);

  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(inValid && !clear) |=> !outValid);

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !(inValid && !clear)) |=> $stable(outSample));

  assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !outValid);

endmodule

bind fir_sym_transposed fir_sym_checker #(.ACC_W(ACC_W)) uCheck (
  .clk       (clk),
  .rst_n     (rst_n),
  .clear     (clear),
  .inValid   (inValid),
  .outValid  (outValid),
  .outSample (outSample)
);

// File: tb/fir_sym_transposed_test.sv
module fir_sym_transposed_test;

  localparam int NT = 31;
  localparam int NU = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inSample = '0;
  logic        coefWrEn = 1'b0;
  logic [4:0]  coefWrIdx = '0;
  logic [15:0] coefWrData = '0;
  logic        coefCommit = 1'b0;
  logic        outValid;
  logic [36:0] outSample;

  fir_sym_transposed uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .inValid    (inValid),
    .inSample   (inSample),
    .coefWrEn   (coefWrEn),
    .coefWrIdx  (coefWrIdx),
    .coefWrData (coefWrData),
    .coefCommit (coefCommit),
    .outValid   (outValid),
    .outSample  (outSample)
  );

  always #10 clk = ~clk;  // 50 MHz

  int errors = 0;
  int checks = 0;

  // Scoreboard queues
  longint expQ[$];
  string  tagQ[$];
  string  curTag = "R2";

  // Reference model state
  int     shadowM [NU];
  int     activeM [NU];
  int     histX   [NT];
  int     histH   [NT][NU];
  longint lastOut = 0;
  int     lcg = 12345;

  function automatic int nextRand();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >>> 8) % 32768 - ((lcg >>> 4) & 1) * 16384;
  endfunction

  task automatic report(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // One clock of stimulus; the model applies the same edge semantics.
  task automatic step(input bit v, input int x, input bit we, input int idx,
                      input int d, input bit cm, input bit clr);
    longint acc;
    @(negedge clk);
    inValid    = v;
    inSample   = 16'(x);
    coefWrEn   = we;
    coefWrIdx  = 5'(idx);
    coefWrData = 16'(d);
    coefCommit = cm;
    clear      = clr;
    if (clr) begin
      for (int k = 0; k < NT; k++) histX[k] = 0;
    end else if (v) begin
      for (int k = NT - 1; k > 0; k--) begin
        histX[k] = histX[k-1];
        for (int u = 0; u < NU; u++) histH[k][u] = histH[k-1][u];
      end
      histX[0] = int'(signed'(16'(x)));
      for (int u = 0; u < NU; u++) histH[0][u] = activeM[u];
      acc = 0;
      for (int k = 0; k < NT; k++) begin
        int u;
        u = (k < NU) ? k : (NT - 1 - k);
        acc += longint'(histH[k][u]) * longint'(histX[k]);
      end
      expQ.push_back(acc);
      tagQ.push_back(curTag);
    end
    if (cm) begin
      for (int u = 0; u < NU; u++) activeM[u] = shadowM[u];
    end
    if (we && idx >= 0 && idx < NU) shadowM[idx] = int'(signed'(16'(d)));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic sample(input int x);
    step(1, x, 0, 0, 0, 0, 0);
  endtask

  task automatic writeW(input int idx, input int d);
    step(0, 0, 1, idx, d, 0, 0);
  endtask

  task automatic commit();
    step(0, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic impulse(input int amp);
    sample(amp);
    for (int i = 0; i < NT; i++) sample(0);
  endtask

  // Monitor: compares every result and the held value between results.
  always @(negedge clk) begin
    if (rst_n) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          report("R5 unexpected outValid", 1, 0);
        end else begin
          longint e;
          string  t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          report(t, longint'($signed(outSample)), e);
          lastOut = longint'($signed(outSample));
        end
      end else begin
        report("R6 hold", longint'($signed(outSample)), lastOut);
      end
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired got 1 expected 0");
    finishRun();
  end

  initial begin
    for (int u = 0; u < NU; u++) begin
      shadowM[u] = 0;
      activeM[u] = 0;
    end
    for (int k = 0; k < NT; k++) begin
      histX[k] = 0;
      for (int u = 0; u < NU; u++) histH[k][u] = 0;
    end

    repeat (4) @(negedge clk);
    report("R1 outValid in reset", longint'(outValid), 0);
    report("R1 outSample in reset", longint'($signed(outSample)), 0);
    rst_n = 1'b1;
    @(negedge clk);
    report("R1 outValid after reset", longint'(outValid), 0);

    // R1: banks start at zero, so outputs are zero before any commit.
    curTag = "R1";
    sample(1234);
    sample(-500);
    idle(2);

    // R3: ramp of distinct weights, impulse shows mirrored taps.
    curTag = "R3";
    for (int u = 0; u < NU; u++) writeW(u, (u + 1) * 3 - 20);
    commit();
    impulse(1000);
    idle(3);

    // R7: out-of-range indices change nothing.
    curTag = "R7";
    writeW(16, 9999);
    writeW(31, -7777);
    writeW(20, 555);
    commit();
    impulse(-700);

    // R8: staged but uncommitted weights have no effect.
    curTag = "R8";
    for (int u = 0; u < NU; u++) writeW(u, 100 - u * 11);
    impulse(321);
    // Commit with a write in the same cycle; sample in that cycle uses old bank.
    step(1, 250, 1, 4, -4444, 1, 0);
    impulse(90);
    commit();
    impulse(90);

    // R2 / R6: mixed stream with gaps.
    curTag = "R2";
    for (int i = 0; i < 70; i++) begin
      sample(nextRand());
      if (i % 3 == 0) begin
        curTag = "R6";
        idle(i % 5 + 1);
        curTag = "R2";
      end
    end

    // R9: commit in the middle of a running stream.
    curTag = "R9";
    for (int u = 0; u < NU; u++) writeW(u, (u % 2 == 0) ? 2000 - u * 50 : -1500 + u * 30);
    for (int i = 0; i < 10; i++) sample(nextRand());
    step(1, 4000, 0, 0, 0, 1, 0);
    for (int i = 0; i < 40; i++) sample(nextRand());

    // R10: clear empties the chain, discards a same-cycle sample, keeps banks.
    curTag = "R10";
    for (int i = 0; i < 8; i++) sample(nextRand());
    step(1, 3000, 0, 0, 0, 0, 1);
    idle(2);
    impulse(555);
    for (int i = 0; i < 5; i++) sample(nextRand());
    step(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 35; i++) sample(nextRand());

    // R4: extreme magnitudes, full-precision result.
    curTag = "R4";
    for (int u = 0; u < NU; u++) writeW(u, -32768);
    commit();
    for (int i = 0; i < NT + 2; i++) sample(-32768);
    for (int u = 0; u < NU; u++) writeW(u, 32767);
    commit();
    for (int i = 0; i < NT + 2; i++) sample(-32768);
    for (int i = 0; i < NT; i++) sample((i % 2 == 0) ? 32767 : -32768);

    idle(4);
    report("R5 all results delivered", longint'(expQ.size()), 0);
    finishRun();
  end

endmodule